// File: doc/BRIEF.md
# Banked NIC Host Register File

This block is the byte-wide host register interface of a legacy Ethernet controller. A host reaches sixteen offsets. Offset 0 always selects the command register. The bank field in the top two command bits widens every other offset into one of four register banks. On many offsets a read returns a different register from the one a write loads. The block holds several groups of registers:

- the receive ring page pointers;
- the transmit page and byte count;
- the remote DMA address and byte count;
- the receive and data configuration bytes;
- the six station address bytes and the eight multicast hash bytes.

These values drive the receive, transmit and DMA engines directly.

The block also owns the interrupt status and mask registers and drives a single interrupt line. Completion strobes from the engines set status bits. The host clears those bits by writing ones. A transmit command gives a one-cycle request strobe to the transmit engine. Reads are combinational and have no side effects.

Top module: `nic_regfile`

## Requirements
- R1: The command register is at offset 0 in every bank. A nonzero offset is decoded as register index {cmd[7:6], offset}. In bank 1, offsets 1-6 are the station bytes, offset 7 is the current page and offsets 8-15 are the hash bytes. In bank 2, reads of offsets 1 and 2 return the start and stop pages.
- R2: After reset the command register reads 0x21, the interrupt status (bank 0, offset 7) reads exactly 0x80, and the interrupt output is low.
- R3: The interrupt output is high exactly when status AND mask AND 0x7F is nonzero, so the reset-complete bit (bit 7) never raises it. The mask is written at bank 0, offset 15.
- R4: A write to the status register clears each of bits 6:0 that is written as 1. Bit 7 is left unchanged by such a write.
- R5: A command write with bit 0 (stop) clear clears status bit 7.
- R6: A command write with bit 0 clear and bit 3 or bit 4 set, made while the remote byte count is zero, sets status bit 6 in the next cycle. With a nonzero count it does not.
- R7: The start page (offset 1) and stop page (offset 2) accept a written value only if it is at most PMEM_END_PG. The boundary (bank 0, offset 3) and the current page (bank 1, offset 7) accept a value only if it is strictly below PMEM_END_PG. A rejected write leaves the old value.
- R8: Each 16-bit value is loaded through a low-byte and a high-byte register, and each write replaces only its own byte. The pairs in bank 0 are: transmit count at offsets 5/6, remote address at 8/9 and remote count at 10/11. The transmit page is at offset 4, the receive configuration at 12 and the data configuration at 14.
- R9: Bank 0 reads of offsets 10 and 11 return 0x50 and 0x43. Bank 3 reads of offsets 3, 5 and 6 return 0x00, 0x40 and 0x40. Reads of unmapped offsets return 0.
- R10: A command write with bit 2 set and bit 0 clear raises tx_req_o for exactly the next cycle. The command register then reads back with bit 2 clear.
- R11: A tx_done_i strobe makes the transmit status (bank 0 read, offset 4) read 0x01 and sets status bit 1.
- R12: rx_done_i sets status bit 0 and dma_done_i sets status bit 6. When a strobe and a host clear of the same bit fall in one cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | 4 | Host register offset |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data (combinational) |
| rx_done_i | input | 1 | Receive-complete strobe |
| tx_done_i | input | 1 | Transmit-complete strobe |
| dma_done_i | input | 1 | Remote-DMA-complete strobe |
| irq_o | output | 1 | Interrupt line |
| tx_req_o | output | 1 | One-cycle transmit request |
| start_pg_o | output | 8 | Ring start page |
| stop_pg_o | output | 8 | Ring stop page |
| bnd_pg_o | output | 8 | Ring boundary page |
| cur_pg_o | output | 8 | Ring current page |
| tx_pg_o | output | 8 | Transmit start page |
| tx_cnt_o | output | 16 | Transmit byte count |
| rdma_addr_o | output | 16 | Remote DMA address |
| rdma_cnt_o | output | 16 | Remote DMA byte count |
| rx_cfg_o | output | 8 | Receive configuration |
| data_cfg_o | output | 8 | Data configuration |
| station_addr_o | output | 48 | Station address, byte 0 in bits 7:0 |
| mcast_hash_o | output | 64 | Multicast hash, byte 0 in bits 7:0 |

## Verification
A completion strobe from an engine and a host write that clears status can land on the same edge, and both target the same status register. The bench provokes this on purpose in two ways. In a directed case it asserts rx_done_i in the very cycle that it writes 1 to bit 0 of the status register. In a random run it mixes random strobes with random clear masks on shared cycles. A reference status byte kept in the bench judges each outcome: masked bits are cleared first and strobed bits are then set. After every cycle the bench compares the status read-back and the interrupt line against that reference.

// File: rtl/nic_reg_pkg.sv
package nic_reg_pkg;
  // effective register index = {bank[1:0], offset[3:0]}
  localparam logic [5:0] IX_START  = 6'h01;
  localparam logic [5:0] IX_STOP   = 6'h02;
  localparam logic [5:0] IX_BND    = 6'h03;
  localparam logic [5:0] IX_TXPG   = 6'h04;
  localparam logic [5:0] IX_TCNT_L = 6'h05;
  localparam logic [5:0] IX_TCNT_H = 6'h06;
  localparam logic [5:0] IX_STAT   = 6'h07;
  localparam logic [5:0] IX_RADR_L = 6'h08;
  localparam logic [5:0] IX_RADR_H = 6'h09;
  localparam logic [5:0] IX_RCNT_L = 6'h0A;
  localparam logic [5:0] IX_RCNT_H = 6'h0B;
  localparam logic [5:0] IX_RXCFG  = 6'h0C;
  localparam logic [5:0] IX_DCFG   = 6'h0E;
  localparam logic [5:0] IX_MASK   = 6'h0F;
  localparam logic [5:0] IX_CURPG  = 6'h17;
  localparam logic [5:0] IX_START_RD = 6'h21;
  localparam logic [5:0] IX_STOP_RD  = 6'h22;
  localparam logic [5:0] IX_CFGA   = 6'h33;
  localparam logic [5:0] IX_CFGC   = 6'h35;
  localparam logic [5:0] IX_CFGD   = 6'h36;

  localparam logic [7:0] ID_BYTE0  = 8'h50;
  localparam logic [7:0] ID_BYTE1  = 8'h43;
  localparam logic [7:0] CFG_LINK  = 8'h40;

  // status bit positions
  localparam int unsigned ST_RX    = 0;
  localparam int unsigned ST_TX    = 1;
  localparam int unsigned ST_DMA   = 6;
  localparam int unsigned ST_RST   = 7;

  // command bit positions
  localparam int unsigned CMD_STOP = 0;
  localparam int unsigned CMD_XMIT = 2;
  localparam int unsigned CMD_RRD  = 3;
  localparam int unsigned CMD_RWR  = 4;
endpackage

// File: rtl/nic_page_reg.sv
module nic_page_reg #(
  parameter int unsigned PW     = 8,
  parameter logic [PW-1:0] END_PG = '1,
  parameter bit          INCL   = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] wdata_i,
  output logic [PW-1:0] q_o
);
  logic in_range;

  generate
    if (INCL) begin : g_incl
      assign in_range = (wdata_i <= END_PG);
    end else begin : g_excl
      assign in_range = (wdata_i < END_PG);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_o <= '0;
    else if (we_i && in_range)  q_o <= wdata_i;
  end
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl #(
  parameter int unsigned SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stat_we_i,
  input  logic          mask_we_i,
  input  logic [SW-1:0] wdata_i,
  input  logic          clr_rst_i,
  input  logic [SW-1:0] set_i,
  output logic [SW-1:0] stat_o,
  output logic [SW-1:0] mask_o,
  output logic          irq_o
);
  localparam logic [SW-1:0] LIVE = {1'b0, {(SW-1){1'b1}}};

  logic [SW-1:0] stat_d;

  always_comb begin
    stat_d = stat_o;
    if (stat_we_i) stat_d = stat_d & ~(wdata_i & LIVE);
    if (clr_rst_i) stat_d[SW-1] = 1'b0;
    stat_d = stat_d | set_i;   // engine events win over host clears
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= {1'b1, {(SW-1){1'b0}}};
      mask_o <= '0;
    end else begin
      stat_o <= stat_d;
      if (mask_we_i) mask_o <= wdata_i;
    end
  end

  assign irq_o = |(stat_o & mask_o & LIVE);
endmodule

// File: rtl/nic_read_mux.sv
module nic_read_mux
  import nic_reg_pkg::*;
#(
  parameter int unsigned N_STA  = 6,
  parameter int unsigned N_HASH = 8
) (
  input  logic [3:0]          off_i,
  input  logic [7:0]          cmd_i,
  input  logic [7:0]          start_i,
  input  logic [7:0]          stop_i,
  input  logic [7:0]          bnd_i,
  input  logic [7:0]          cur_i,
  input  logic [7:0]          tsr_i,
  input  logic [7:0]          stat_i,
  input  logic [15:0]         radr_i,
  input  logic [8*N_STA-1:0]  sta_i,
  input  logic [8*N_HASH-1:0] hash_i,
  output logic [7:0]          rdata_o
);
  logic [1:0] bank;
  logic [5:0] idx;

  assign bank = cmd_i[7:6];
  assign idx  = {bank, off_i};

  always_comb begin
    rdata_o = '0;
    if (off_i == 4'd0) begin
      rdata_o = cmd_i;
    end else if (bank == 2'd1 && int'(off_i) <= N_STA) begin
      rdata_o = sta_i[8*(int'(off_i)-1) +: 8];
    end else if (bank == 2'd1 && int'(off_i) >= 8 && int'(off_i) < 8 + N_HASH) begin
      rdata_o = hash_i[8*(int'(off_i)-8) +: 8];
    end else begin
      unique case (idx)
        IX_BND:      rdata_o = bnd_i;
        IX_TXPG:     rdata_o = tsr_i;
        IX_STAT:     rdata_o = stat_i;
        IX_RADR_L:   rdata_o = radr_i[7:0];
        IX_RADR_H:   rdata_o = radr_i[15:8];
        IX_RCNT_L:   rdata_o = ID_BYTE0;
        IX_RCNT_H:   rdata_o = ID_BYTE1;
        IX_CURPG:    rdata_o = cur_i;
        IX_START_RD: rdata_o = start_i;
        IX_STOP_RD:  rdata_o = stop_i;
        IX_CFGA:     rdata_o = 8'h00;
        IX_CFGC:     rdata_o = CFG_LINK;
        IX_CFGD:     rdata_o = CFG_LINK;
        default:     rdata_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
  import nic_reg_pkg::*;
#(
  parameter logic [7:0]  PMEM_END_PG = 8'hC0,
  parameter logic [7:0]  CMD_RST     = 8'h21,
  parameter int unsigned N_STA       = 6,
  parameter int unsigned N_HASH      = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [3:0]          addr_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  input  logic                rx_done_i,
  input  logic                tx_done_i,
  input  logic                dma_done_i,
  output logic                irq_o,
  output logic                tx_req_o,
  output logic [7:0]          start_pg_o,
  output logic [7:0]          stop_pg_o,
  output logic [7:0]          bnd_pg_o,
  output logic [7:0]          cur_pg_o,
  output logic [7:0]          tx_pg_o,
  output logic [15:0]         tx_cnt_o,
  output logic [15:0]         rdma_addr_o,
  output logic [15:0]         rdma_cnt_o,
  output logic [7:0]          rx_cfg_o,
  output logic [7:0]          data_cfg_o,
  output logic [8*N_STA-1:0]  station_addr_o,
  output logic [8*N_HASH-1:0] mcast_hash_o
);
  localparam int unsigned N_PTR   = 4;
  localparam logic [N_PTR-1:0] PTR_INCL = 4'b0011;   // start, stop inclusive

  logic [7:0] cmd_q;
  logic [7:0] tsr_q;
  logic [7:0] isr, imr;
  logic [5:0] idx;
  logic       wr_cmd, wr_reg, go_cmd, tx_start, dma_zero;
  logic [7:0] stat_set;
  logic [N_PTR-1:0] ptr_we;
  logic [7:0] ptr_q [N_PTR];
  logic [7:0] sta_q  [N_STA];
  logic [7:0] hash_q [N_HASH];

  assign idx      = {cmd_q[7:6], addr_i};
  assign wr_cmd   = wr_en_i && (addr_i == 4'd0);
  assign wr_reg   = wr_en_i && (addr_i != 4'd0);
  assign go_cmd   = wr_cmd && !wdata_i[CMD_STOP];
  assign tx_start = go_cmd && wdata_i[CMD_XMIT];
  assign dma_zero = go_cmd && (wdata_i[CMD_RRD] || wdata_i[CMD_RWR]) && (rdma_cnt_o == 16'd0);

  // command register and transmit strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= CMD_RST;
      tx_req_o <= 1'b0;
    end else begin
      tx_req_o <= tx_start;
      if (wr_cmd) cmd_q <= tx_start ? (wdata_i & ~(8'h1 << CMD_XMIT)) : wdata_i;
    end
  end

  // ring page pointers with range gating
  assign ptr_we[0] = wr_reg && (idx == IX_START);
  assign ptr_we[1] = wr_reg && (idx == IX_STOP);
  assign ptr_we[2] = wr_reg && (idx == IX_BND);
  assign ptr_we[3] = wr_reg && (idx == IX_CURPG);

  generate
    for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
      nic_page_reg #(
        .PW     (8),
        .END_PG (PMEM_END_PG),
        .INCL   (PTR_INCL[g])
      ) u_ptr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (ptr_we[g]),
        .wdata_i (wdata_i),
        .q_o     (ptr_q[g])
      );
    end
  endgenerate

  assign start_pg_o = ptr_q[0];
  assign stop_pg_o  = ptr_q[1];
  assign bnd_pg_o   = ptr_q[2];
  assign cur_pg_o   = ptr_q[3];

  // byte-lane loaded words and plain config bytes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_pg_o     <= '0;
      tx_cnt_o    <= '0;
      rdma_addr_o <= '0;
      rdma_cnt_o  <= '0;
      rx_cfg_o    <= '0;
      data_cfg_o  <= '0;
      tsr_q       <= '0;
    end else begin
      if (tx_done_i) tsr_q <= 8'h01;
      if (wr_reg) begin
        unique case (idx)
          IX_TXPG:   tx_pg_o           <= wdata_i;
          IX_TCNT_L: tx_cnt_o[7:0]     <= wdata_i;
          IX_TCNT_H: tx_cnt_o[15:8]    <= wdata_i;
          IX_RADR_L: rdma_addr_o[7:0]  <= wdata_i;
          IX_RADR_H: rdma_addr_o[15:8] <= wdata_i;
          IX_RCNT_L: rdma_cnt_o[7:0]   <= wdata_i;
          IX_RCNT_H: rdma_cnt_o[15:8]  <= wdata_i;
          IX_RXCFG:  rx_cfg_o          <= wdata_i;
          IX_DCFG:   data_cfg_o        <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  // station address and hash filter bytes, bank 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_STA; i++)  sta_q[i]  <= '0;
      for (int i = 0; i < N_HASH; i++) hash_q[i] <= '0;
    end else if (wr_reg && cmd_q[7:6] == 2'd1) begin
      for (int i = 0; i < N_STA; i++)
        if (int'(addr_i) == i + 1) sta_q[i] <= wdata_i;
      for (int i = 0; i < N_HASH; i++)
        if (int'(addr_i) == i + 8) hash_q[i] <= wdata_i;
    end
  end

  generate
    for (genvar s = 0; s < N_STA; s++) begin : g_sta
      assign station_addr_o[8*s +: 8] = sta_q[s];
    end
    for (genvar h = 0; h < N_HASH; h++) begin : g_hash
      assign mcast_hash_o[8*h +: 8] = hash_q[h];
    end
  endgenerate

  // interrupt status and mask
  always_comb begin
    stat_set          = '0;
    stat_set[ST_RX]   = rx_done_i;
    stat_set[ST_TX]   = tx_done_i;
    stat_set[ST_DMA]  = dma_done_i || dma_zero;
  end

  nic_irq_ctrl #(.SW(8)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stat_we_i (wr_reg && idx == IX_STAT),
    .mask_we_i (wr_reg && idx == IX_MASK),
    .wdata_i   (wdata_i),
    .clr_rst_i (go_cmd),
    .set_i     (stat_set),
    .stat_o    (isr),
    .mask_o    (imr),
    .irq_o     (irq_o)
  );

  nic_read_mux #(.N_STA(N_STA), .N_HASH(N_HASH)) u_rd (
    .off_i   (addr_i),
    .cmd_i   (cmd_q),
    .start_i (start_pg_o),
    .stop_i  (stop_pg_o),
    .bnd_i   (bnd_pg_o),
    .cur_i   (cur_pg_o),
    .tsr_i   (tsr_q),
    .stat_i  (isr),
    .radr_i  (rdma_addr_o),
    .sta_i   (station_addr_o),
    .hash_i  (mcast_hash_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/nic_regfile_chk.sv
module nic_regfile_chk #(
  parameter logic [7:0] PMEM_END_PG = 8'hC0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [3:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic        rx_done_i,
  input logic        tx_done_i,
  input logic        irq_o,
  input logic        tx_req_o,
  input logic [7:0]  start_pg_o,
  input logic [7:0]  stop_pg_o,
  input logic [7:0]  bnd_pg_o,
  input logic [7:0]  cur_pg_o,
  input logic [15:0] tx_cnt_o,
  input logic [15:0] rdma_cnt_o,
  input logic [7:0]  isr,
  input logic [7:0]  cmd_q
);
  assert_rst_no_irq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr[6:0] == 7'd0) |-> !irq_o);

  assert_rst_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr[7] && wr_en_i && addr_i == 4'd7 && cmd_q[7:6] == 2'd0) |=> isr[7]);

  assert_rst_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'd0 && !wdata_i[0]) |=> !isr[7]);

  assert_zero_dma_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'd0 && !wdata_i[0] && (wdata_i[3] || wdata_i[4])
     && rdma_cnt_o == 16'd0) |=> isr[6]);

  assert_ptr_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_pg_o <= PMEM_END_PG) && (stop_pg_o <= PMEM_END_PG)
    && (bnd_pg_o < PMEM_END_PG) && (cur_pg_o < PMEM_END_PG));

  assert_lo_byte_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'd5 && cmd_q[7:6] == 2'd0) |=> $stable(tx_cnt_o[15:8]));

  assert_tx_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> $past(wr_en_i && addr_i == 4'd0 && wdata_i[2] && !wdata_i[0]));

  assert_tx_evt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> isr[1]);

  assert_rx_evt_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i |=> isr[0]);
endmodule

bind nic_regfile nic_regfile_chk #(.PMEM_END_PG(PMEM_END_PG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rx_done_i  (rx_done_i),
  .tx_done_i  (tx_done_i),
  .irq_o      (irq_o),
  .tx_req_o   (tx_req_o),
  .start_pg_o (start_pg_o),
  .stop_pg_o  (stop_pg_o),
  .bnd_pg_o   (bnd_pg_o),
  .cur_pg_o   (cur_pg_o),
  .tx_cnt_o   (tx_cnt_o),
  .rdma_cnt_o (rdma_cnt_o),
  .isr        (isr),
  .cmd_q      (cmd_q)
);

// File: tb/nic_regfile_tb.sv
`timescale 1ns/1ps
module nic_regfile_tb;
  localparam logic [7:0] END_PG = 8'hC0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        rx_done = 1'b0, tx_done = 1'b0, dma_done = 1'b0;
  logic [7:0]  rdata;
  logic        irq, tx_req;
  logic [7:0]  start_pg, stop_pg, bnd_pg, cur_pg, tx_pg, rx_cfg, data_cfg;
  logic [15:0] tx_cnt, rdma_addr, rdma_cnt;
  logic [47:0] sta;
  logic [63:0] hash;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nic_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rx_done_i(rx_done), .tx_done_i(tx_done), .dma_done_i(dma_done),
    .irq_o(irq), .tx_req_o(tx_req), .start_pg_o(start_pg), .stop_pg_o(stop_pg),
    .bnd_pg_o(bnd_pg), .cur_pg_o(cur_pg), .tx_pg_o(tx_pg), .tx_cnt_o(tx_cnt),
    .rdma_addr_o(rdma_addr), .rdma_cnt_o(rdma_cnt), .rx_cfg_o(rx_cfg),
    .data_cfg_o(data_cfg), .station_addr_o(sta), .mcast_hash_o(hash)
  );

  function automatic logic exp_irq(input logic [7:0] st, input logic [7:0] mk);
    return |(st & mk & 8'h7F);
  endfunction

  function automatic logic ptr_ok(input logic [7:0] v, input bit incl);
    return incl ? (v <= END_PG) : (v < END_PG);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] m_isr, m_imr;
    logic [7:0] m_ptr [4];
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(4'd0, v); chk("R2 cmd reset", v, 8'h21);
    rd(4'd7, v); chk("R2 status reset", v, 8'h80);
    chk("R2 irq reset", irq, 1'b0);

    // R3 reset bit never interrupts
    wr(4'd15, 8'hFF);
    chk("R3 reset bit masked from irq", irq, 1'b0);

    // R4 status write leaves bit7
    wr(4'd7, 8'h80);
    rd(4'd7, v); chk("R4 bit7 kept", v, 8'h80);

    // R5/R6 go with remote read, zero count
    wr(4'd0, 8'h0A);
    rd(4'd7, v); chk("R5 R6 status after go", v, 8'h40);
    chk("R6 irq on dma", irq, 1'b1);
    wr(4'd7, 8'h40);
    rd(4'd7, v); chk("R4 w1c dma bit", v, 8'h00);
    chk("R3 irq low after clear", irq, 1'b0);

    // R8 byte lanes; R6 nonzero count gives no event
    wr(4'd10, 8'h05);
    chk("R8 rcnt low", rdma_cnt, 16'h0005);
    wr(4'd11, 8'h12);
    chk("R8 rcnt high", rdma_cnt, 16'h1205);
    wr(4'd10, 8'h34);
    chk("R8 rcnt low only", rdma_cnt, 16'h1234);
    wr(4'd0, 8'h12);
    rd(4'd7, v); chk("R6 no event with count", v, 8'h00);
    wr(4'd8, 8'hA5); wr(4'd9, 8'h3C);
    chk("R8 radr", rdma_addr, 16'h3CA5);
    rd(4'd9, v); chk("R8 radr high read", v, 8'h3C);
    wr(4'd12, 8'h0C); wr(4'd14, 8'h49);
    chk("R8 cfg bytes", {rx_cfg, data_cfg}, 16'h0C49);

    // R7 page limits
    wr(4'd1, 8'hC0); chk("R7 start at end", start_pg, 8'hC0);
    wr(4'd1, 8'hC1); chk("R7 start above end", start_pg, 8'hC0);
    wr(4'd3, 8'hC0); chk("R7 bnd at end", bnd_pg, 8'h00);
    wr(4'd3, 8'hBF); chk("R7 bnd below end", bnd_pg, 8'hBF);
    wr(4'd2, 8'h80); chk("R7 stop", stop_pg, 8'h80);

    // R1 banks
    wr(4'd0, 8'hA2);
    rd(4'd0, v); chk("R1 cmd in bank2", v, 8'hA2);
    rd(4'd1, v); chk("R1 bank2 start", v, 8'hC0);
    rd(4'd2, v); chk("R1 bank2 stop", v, 8'h80);
    wr(4'd0, 8'h62);
    wr(4'd7, 8'hC0); chk("R7 cur at end", cur_pg, 8'h00);
    wr(4'd7, 8'h05); chk("R7 cur below", cur_pg, 8'h05);
    rd(4'd7, v); chk("R1 bank1 offset7 is cur", v, 8'h05);
    for (int i = 1; i <= 6; i++) wr(4'(i), 8'(8'h10 + i));
    for (int i = 8; i <= 15; i++) wr(4'(i), 8'(8'h80 + i));
    chk("R1 station", sta, 48'h161514131211);
    chk("R1 hash", hash, 64'h8F8E8D8C8B8A8988);
    rd(4'd3, v); chk("R1 station read", v, 8'h13);
    rd(4'd12, v); chk("R1 hash read", v, 8'h8C);
    chk("R1 bank1 leaves bank0 regs", {start_pg, bnd_pg}, 16'hC0BF);

    // R9 constants
    wr(4'd0, 8'hE2);
    rd(4'd3, v); chk("R9 cfg a", v, 8'h00);
    rd(4'd5, v); chk("R9 cfg c", v, 8'h40);
    rd(4'd6, v); chk("R9 cfg d", v, 8'h40);
    rd(4'd4, v); chk("R9 unmapped bank3", v, 8'h00);
    wr(4'd0, 8'h22);
    rd(4'd10, v); chk("R9 id0", v, 8'h50);
    rd(4'd11, v); chk("R9 id1", v, 8'h43);
    rd(4'd13, v); chk("R9 unmapped bank0", v, 8'h00);

    // R10 transmit strobe
    wr(4'd4, 8'h10); wr(4'd5, 8'h3C); wr(4'd6, 8'h01);
    chk("R8 tx page/count", {tx_pg, tx_cnt}, 24'h10013C);
    wr(4'd0, 8'h26);
    chk("R10 tx_req high", tx_req, 1'b1);
    rd(4'd0, v);
    chk("R10 tx_req one cycle", tx_req, 1'b0);
    chk("R10 xmit bit reads clear", v, 8'h22);

    // R11 transmit done
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    rd(4'd4, v); chk("R11 tsr", v, 8'h01);
    rd(4'd7, v); chk("R11 status bit1", v, 8'h02);

    // R12 event and clear in the same cycle
    @(negedge clk);
    rx_done = 1'b1; addr = 4'd7; wdata = 8'h03; wr_en = 1'b1;
    @(negedge clk);
    rx_done = 1'b0; wr_en = 1'b0;
    #1 chk("R12 event beats clear", rdata, 8'h01);

    // random status traffic against reference
    m_isr = 8'h01; m_imr = 8'hFF;
    for (int it = 0; it < 400; it++) begin
      logic [7:0] setv, clrv;
      bit do_clr;
      if (it % 32 == 0) begin
        m_imr = 8'($urandom);
        wr(4'd15, m_imr);
      end
      @(negedge clk);
      rx_done  = 1'($urandom);
      tx_done  = ($urandom % 4) == 0;
      dma_done = ($urandom % 4) == 0;
      do_clr   = ($urandom % 2) == 0;
      clrv     = 8'($urandom);
      addr = 4'd7; wdata = clrv; wr_en = do_clr;
      setv = {1'b0, dma_done, 4'b0, tx_done, rx_done};
      if (do_clr) m_isr = m_isr & ~(clrv & 8'h7F);
      m_isr = m_isr | setv;
      @(negedge clk);
      rx_done = 1'b0; tx_done = 1'b0; dma_done = 1'b0; wr_en = 1'b0;
      #1;
      chk("R12 R4 random status", rdata, m_isr);
      chk("R3 random irq", irq, exp_irq(m_isr, m_imr));
    end

    // random page pointer writes
    m_ptr[0] = start_pg; m_ptr[1] = stop_pg; m_ptr[2] = bnd_pg; m_ptr[3] = cur_pg;
    for (int it = 0; it < 120; it++) begin
      int sel;
      logic [7:0] pv;
      sel = int'($urandom % 4);
      pv  = (it % 3 == 0) ? 8'(8'hBE + ($urandom % 4)) : 8'($urandom);
      if (sel == 3) begin
        wr(4'd0, 8'h62); wr(4'd7, pv); wr(4'd0, 8'h22);
      end else begin
        wr(4'(sel + 1), pv);
      end
      if (ptr_ok(pv, sel < 2)) m_ptr[sel] = pv;
      chk("R7 random pointers", {start_pg, stop_pg, bnd_pg, cur_pg},
          {m_ptr[0], m_ptr[1], m_ptr[2], m_ptr[3]});
    end

    done = 1'b1;
    finish_run();
  end
endmodule